// File: doc/BRIEF.md
# Edge-Synchronized Two-Point Supply Regulator

This block drives the pass switch that holds the chip supply inside a voltage window while the chip is in operating mode. Three digitized comparator flags describe where the supply sits: above a forcing threshold, above the turn-on threshold, or below the turn-off threshold. A fourth input is the low-side gate command of the half-bridge. The switch is changed in step with that command, so that switching happens on its falling edge, unless the supply is high enough that the switch must close at once.

Within the normal band the regulator waits for a falling edge of the synchronized low-side command. It then closes the switch if the supply is above the turn-on threshold, opens it if the supply is below the turn-off threshold, and otherwise leaves it as it was. The flags are read in the same cycle as the edge, and a request is never carried over to a later edge. When the mode sequencer withdraws its enable, the switch is forced open on the next clock.

Top module: `supply_window_reg`

## Requirements
- R1: While `rst_n` is low, and at the first clock after reset is released, `pass_sw_on` is 0.
- R2: When `op_mode_en` is 0 at a clock edge, `pass_sw_on` is 0 after that edge, whatever the flags and `low_gate_cmd` do.
- R3: With `op_mode_en` at 1 and `supply_above_force` at 1 at a clock edge, `pass_sw_on` is 1 after that edge, with no falling edge of `low_gate_cmd` needed.
- R4: With the supply in the turn-on band (`supply_above_on` = 1, `supply_above_force` = 0), a falling edge of `low_gate_cmd` closes the switch. With SYNC_STAGES = 2, `pass_sw_on` becomes 1 at the third rising clock edge after the input falls and not earlier.
- R5: With the supply below the turn-off threshold (`supply_below_off` = 1, the other two flags 0), a falling edge of `low_gate_cmd` opens the switch, with the same three-edge latency as R4.
- R6: With all three flags at 0 (the hysteresis band), a falling edge of `low_gate_cmd` leaves `pass_sw_on` unchanged, whether it is 0 or 1.
- R7: Without a falling edge of `low_gate_cmd`, a rising edge or a steady level leaves `pass_sw_on` unchanged in the turn-on and turn-off bands.
- R8: The flags are read in the clock cycle that acts on the edge: flag values present only before that cycle, or only after it, have no effect, and no request is kept for a later edge.
- R9: When the flags conflict, the forcing flag takes priority over the turn-on flag, and the turn-on flag takes priority over the turn-off flag. All flags are active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode_en | input | 1 | Operating-mode enable from the mode sequencer |
| supply_above_force | input | 1 | Supply is above the immediate-on threshold |
| supply_above_on | input | 1 | Supply is above the turn-on threshold |
| supply_below_off | input | 1 | Supply is below the turn-off threshold |
| low_gate_cmd | input | 1 | Low-side gate command, asynchronous to `clk` |
| pass_sw_on | output | 1 | Pass switch command, 1 = closed |

## Verification
The forcing flag and the enable both act on the clock edge that follows them, so their checks sample one cycle after the stimulus. A falling edge of `low_gate_cmd` passes two synchronizer stages and the previous-sample register before it is acted on. The bench therefore checks that the output has not moved two cycles after the input falls and has moved at the third. All stimulus is applied and all outputs are sampled on the falling clock edge, so each check lands between two known rising edges. For the sampling-window case, the flags are changed in the cycles before and after the acting cycle.

// File: rtl/supply_window_pkg.sv
// Shared types for the two-point supply regulator.
// Assumes: threshold flags are active high and already synchronous to clk.
package supply_window_pkg;

    // Supply band as seen by the regulator, listed in priority order.
    typedef enum logic [1:0] {
        BAND_FORCE = 2'd0,  // above immediate-on threshold
        BAND_ON    = 2'd1,  // above turn-on threshold
        BAND_OFF   = 2'd2,  // below turn-off threshold
        BAND_HOLD  = 2'd3   // hysteresis band
    } supply_band_t;

    // Map the three flags to a band; conflicting flags resolve by priority.
    function automatic supply_band_t classify_band(
        input logic above_force,
        input logic above_on,
        input logic below_off
    );
        if (above_force)     return BAND_FORCE;
        else if (above_on)   return BAND_ON;
        else if (below_off)  return BAND_OFF;
        else                 return BAND_HOLD;
    endfunction

endpackage

// File: rtl/swr_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes: STAGES >= 1; the synchronized value resets to 0.
module swr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Capture the input into the only stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            // Shift the input through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/swr_fall_detect.sv
// Falling-edge detector that compares the current sample with a registered copy.
// Assumes: sample_in is synchronous to clk; the stored copy resets to 0.
module swr_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_in,
    output logic fall_pulse
);

    logic prev_q;

    // Keep the previous sample of the synchronized command.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sample_in;
    end

    assign fall_pulse = prev_q & ~sample_in;

endmodule

// File: rtl/swr_switch_ctl.sv
// Pass-switch state register with band-dependent update rules.
// Forcing band closes at once; other bands act only on an edge pulse;
// disable clears the switch on the next clock.
// Assumes: flags are synchronous to clk and are read in the edge cycle.
module swr_switch_ctl
    import supply_window_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic above_force,
    input  logic above_on,
    input  logic below_off,
    input  logic edge_pulse,
    output logic switch_on
);

    supply_band_t band;
    logic         sw_d;
    logic         sw_q;

    // Classify the present supply band from the flags.
    always_comb band = classify_band(above_force, above_on, below_off);

    // Select the next switch state from enable, band and edge.
    always_comb begin
        sw_d = sw_q;
        if (!enable) begin
            sw_d = 1'b0;
        end else if (band == BAND_FORCE) begin
            sw_d = 1'b1;
        end else if (edge_pulse) begin
            case (band)
                BAND_ON:  sw_d = 1'b1;
                BAND_OFF: sw_d = 1'b0;
                default:  sw_d = sw_q;
            endcase
        end
    end

    // Hold the switch state.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= 1'b0;
        else        sw_q <= sw_d;
    end

    assign switch_on = sw_q;

endmodule

// File: rtl/supply_window_reg.sv
// Two-point supply regulator top: synchronizes the low-side gate command,
// finds its falling edge and updates the pass-switch command.
// Assumes: low_gate_cmd is asynchronous; all other inputs are synchronous.
module supply_window_reg #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_mode_en,
    input  logic supply_above_force,
    input  logic supply_above_on,
    input  logic supply_below_off,
    input  logic low_gate_cmd,
    output logic pass_sw_on
);

    logic gate_sync;
    logic gate_fall;

    swr_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (low_gate_cmd),
        .sync_out (gate_sync)
    );

    swr_fall_detect u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (gate_sync),
        .fall_pulse (gate_fall)
    );

    swr_switch_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (op_mode_en),
        .above_force (supply_above_force),
        .above_on    (supply_above_on),
        .below_off   (supply_below_off),
        .edge_pulse  (gate_fall),
        .switch_on   (pass_sw_on)
    );

endmodule

// File: rtl/supply_window_chk.sv
// Property checker for the two-point supply regulator, bound to the top.
// Assumes: fall is the detected falling-edge pulse of the synchronized command.
module supply_window_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic f_force,
    input logic f_on,
    input logic f_off,
    input logic fall,
    input logic sw
);

    logic rst_seen_q;

    // Remember whether reset was asserted at the previous edge.
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    // R1: the switch is open right after a reset edge.
    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b0) a_r1_reset_open: assert (!sw);
    end

    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sw);

    a_r3_force_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (en && f_force) |=> sw);

    a_r4_edge_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !f_force && f_on && fall) |=> sw);

    // R9: the turn-off flag is ignored while the turn-on flag is set.
    a_r5_edge_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !f_force && !f_on && f_off && fall) |=> !sw);

    a_r6_hysteresis_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !f_force && !f_on && !f_off && fall) |=> $stable(sw));

    a_r7_no_edge_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !f_force && !fall) |=> $stable(sw));

endmodule

bind supply_window_reg supply_window_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (op_mode_en),
    .f_force (supply_above_force),
    .f_on    (supply_above_on),
    .f_off   (supply_below_off),
    .fall    (gate_fall),
    .sw      (pass_sw_on)
);

// File: tb/supply_window_reg_test.sv
// Directed bench for the two-point supply regulator. Inputs change and
// outputs are sampled on the falling clock edge.
module supply_window_reg_test;

    logic clk = 1'b0;
    logic rst_n;
    logic en;
    logic f_force;
    logic f_on;
    logic f_off;
    logic lgc;
    logic sw;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    supply_window_reg #(.SYNC_STAGES(2)) uut (
        .clk                (clk),
        .rst_n              (rst_n),
        .op_mode_en         (en),
        .supply_above_force (f_force),
        .supply_above_on    (f_on),
        .supply_below_off   (f_off),
        .low_gate_cmd       (lgc),
        .pass_sw_on         (sw)
    );

    task automatic check(input logic exp, input string req);
        n_run++;
        if (sw !== exp) begin
            n_fail++;
            $display("FAIL %s: pass_sw_on=%b expected %b at %0t", req, sw, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_flags(input logic fo, input logic on, input logic off);
        f_force = fo;
        f_on    = on;
        f_off   = off;
    endtask

    // Raise the command, let it settle, then drop it at a falling clock edge.
    task automatic drop_gate();
        lgc = 1'b1;
        wait_n(4);
        lgc = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; lgc = 1'b0;
        set_flags(1'b0, 1'b0, 1'b0);
        wait_n(3);
        check(1'b0, "R1 during reset");
        rst_n = 1'b1;
        en    = 1'b1;
        wait_n(1);
        check(1'b0, "R1 after release");
    endtask

    task automatic t_edge_on();
        set_flags(1'b0, 1'b1, 1'b0);
        lgc = 1'b1;
        wait_n(4);
        check(1'b0, "R7 rising edge ignored");
        lgc = 1'b0;
        wait_n(2);
        check(1'b0, "R4 not before third edge");
        wait_n(1);
        check(1'b1, "R4 closes on falling edge");
    endtask

    task automatic t_edge_off();
        set_flags(1'b0, 1'b0, 1'b1);
        wait_n(5);
        check(1'b1, "R7 off band without edge");
        drop_gate();
        wait_n(2);
        check(1'b1, "R5 not before third edge");
        wait_n(1);
        check(1'b0, "R5 opens on falling edge");
    endtask

    task automatic t_hysteresis();
        set_flags(1'b0, 1'b0, 1'b0);
        drop_gate();
        wait_n(4);
        check(1'b0, "R6 hold open");
        set_flags(1'b0, 1'b1, 1'b0);
        drop_gate();
        wait_n(4);
        check(1'b1, "R4 close before hold test");
        set_flags(1'b0, 1'b0, 1'b0);
        drop_gate();
        wait_n(4);
        check(1'b1, "R6 hold closed");
        set_flags(1'b0, 1'b0, 1'b1);
        drop_gate();
        wait_n(4);
        check(1'b0, "R5 reopen");
    endtask

    task automatic t_force();
        f_force = 1'b1;
        wait_n(1);
        check(1'b1, "R3 immediate close");
        set_flags(1'b0, 1'b0, 1'b1);
        wait_n(4);
        check(1'b1, "R7 stays closed without edge");
        set_flags(1'b1, 1'b0, 1'b1);
        drop_gate();
        wait_n(4);
        check(1'b1, "R9 force beats off");
        set_flags(1'b0, 1'b0, 1'b1);
        drop_gate();
        wait_n(4);
        check(1'b0, "R5 open before priority test");
        set_flags(1'b0, 1'b1, 1'b1);
        drop_gate();
        wait_n(4);
        check(1'b1, "R9 on beats off");
        set_flags(1'b0, 1'b0, 1'b1);
        drop_gate();
        wait_n(4);
        check(1'b0, "R5 open after priority test");
    endtask

    task automatic t_sample_window();
        set_flags(1'b0, 1'b0, 1'b0);
        lgc = 1'b1;
        wait_n(4);
        lgc = 1'b0;
        wait_n(1);
        f_on = 1'b1;
        wait_n(1);
        f_on = 1'b0;
        wait_n(1);
        check(1'b0, "R8 flag before edge cycle ignored");
        f_on = 1'b1;
        wait_n(5);
        check(1'b0, "R8 no queued request");
        f_on = 1'b0;
        lgc = 1'b1;
        wait_n(4);
        lgc = 1'b0;
        wait_n(2);
        f_on = 1'b1;
        wait_n(1);
        check(1'b1, "R8 flag in edge cycle used");
        set_flags(1'b0, 1'b0, 1'b0);
        wait_n(2);
    endtask

    task automatic t_disable();
        en = 1'b0;
        wait_n(1);
        check(1'b0, "R2 disable clears");
        set_flags(1'b1, 1'b1, 1'b0);
        drop_gate();
        wait_n(4);
        check(1'b0, "R2 disabled ignores flags and edge");
        en = 1'b1;
        wait_n(1);
        check(1'b1, "R3 close after re-enable");
        en = 1'b0;
        wait_n(1);
        check(1'b0, "R2 disable over force");
        en = 1'b1;
        set_flags(1'b0, 1'b0, 1'b0);
        wait_n(2);
        check(1'b0, "R6 hold after re-enable");
    endtask

    initial begin
        wait_n(1);
        t_reset();
        t_edge_on();
        t_edge_off();
        t_hysteresis();
        t_force();
        t_sample_window();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule